// File: doc/BRIEF.md
# Pushbutton On/Off Debounce Sequencer

This block takes a raw active-low pushbutton level and turns it into a debounced power state that toggles on each valid press. A press is accepted in two steps. First the button must stay low for a fixed base interval. Then it must stay low for a further programmable interval. The length of that second interval is set by one count when the block is off (a turn-on request) and by another count when it is on (a turn-off request). Each press that is accepted must be followed by a debounced release before the next press can be seen. All timing is counted in pulses of a one-millisecond timebase enable.

A turn-off request raises an early warning. Once the base interval has passed, an active-low interrupt goes low. If the button is let go before the extra off interval ends, the interrupt is released and nothing else happens. If the button is still held when that interval ends, the block sends a one-cycle shutdown request. The power state stays high and the interrupt stays low until the system returns a shutdown-done strobe.

Top module: `pb_onoff_seq`

## Requirements
- R1: After reset, power_on is 0, int_n is 1 and shdn_req is 0, and the block is waiting for a press.
- R2: A low level held for fewer than BASE_TICKS timebase ticks (default 26) is ignored: power_on, int_n and shdn_req do not change.
- R3: While power_on is 0, a press held for BASE_TICKS plus on_extra ticks sets power_on to 1. int_n stays 1 during such a press.
- R4: While power_on is 1, int_n goes low once a press has lasted BASE_TICKS ticks, and not before. int_n is low only while power_on is 1.
- R5: If the button is released during the extra off interval, int_n returns to 1 within a few clock cycles, no shdn_req is issued and power_on stays 1.
- R6: A press that completes the extra off interval gives exactly one single-cycle shdn_req pulse. power_on stays 1 and int_n stays 0 until shdn_done is seen. After that, power_on is 0 and int_n is 1.
- R7: The extra interval comes from on_extra while power_on is 0 and from off_extra while power_on is 1.
- R8: After an accepted press, the button must stay high for BASE_TICKS consecutive ticks before a new press is recognized. Any low level during that time restarts the count.
- R9: An extra count of 0 makes a press valid as soon as the base interval ends.
- R10: pb_n passes through a two-flop synchronizer. All intervals are counted only on cycles where tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase enable, nominally every 1 ms |
| pb_n | input | 1 | Asynchronous pushbutton level, low when pressed |
| on_extra | input | CNT_W | Extra hold ticks for a turn-on press |
| off_extra | input | CNT_W | Extra hold ticks for a turn-off press |
| shdn_done | input | 1 | Strobe marking the end of the shutdown sequence |
| power_on | output | 1 | Debounced power state, 1 after a turn-on |
| int_n | output | 1 | Active-low pending turn-off interrupt |
| shdn_req | output | 1 | One-cycle shutdown request pulse |

## Verification
The presses are chosen to fall clearly on either side of each threshold. Short presses that never finish the base interval show that the base timer gates everything. Presses that pass the base interval but stop before the state-specific extra interval ends separate the on count from the off count. Long presses, including one with an extra count of zero, show that the state toggles. A turn-off press released partway through proves that the interrupt can be cancelled. A delayed shutdown-done strobe shows that the power state is held. A glitch during the release debounce, followed by a long press, shows that the release count restarts and that the press is ignored.

// File: rtl/pbs_pkg.sv
// Package: shared types for the pushbutton on/off sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,  // waiting for a press
        ST_BASE      = 3'd1,  // counting fixed base hold
        ST_EXTRA     = 3'd2,  // counting state-specific extra hold
        ST_WAIT_DONE = 3'd3,  // turn-off accepted, awaiting shutdown done
        ST_RELEASE   = 3'd4   // counting release debounce
    } pbs_state_e;
endpackage

// File: rtl/pbs_sync.sv
// Module: multi-flop level synchronizer.
// Assumes: input is a slow asynchronous level; reset value is the idle (high) level.
module pbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pbs_tick_counter.sv
// Module: saturating counter that advances on timebase ticks.
// Assumes: clear has priority over counting; count holds at its maximum value.
module pbs_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // clear, or advance on a tick until saturated
    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (clr)                        count <= '0;
        else if (tick && (count != CNT_MAX)) count <= count + 1'b1;
    end
endmodule

// File: rtl/pbs_ctrl.sv
// Module: press/release tracker and power-state sequencer.
// Assumes: pb_low is synchronized; count comes from a tick counter cleared by clr.
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int BASE_TICKS = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pb_low,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] on_extra,
    input  logic [CNT_W-1:0] off_extra,
    input  logic             shdn_done,
    output logic             clr,
    output logic             power_on,
    output logic             int_n,
    output logic             shdn_req
);
    localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(BASE_TICKS - 1);

    pbs_state_e       state, state_nxt;
    logic             set_on, clr_on, req_set;
    logic [CNT_W-1:0] extra_sel;

    // the extra hold depends on which command the press would give
    assign extra_sel = power_on ? off_extra : on_extra;

    // next state and counter control
    always_comb begin
        state_nxt = state;
        clr       = 1'b0;
        set_on    = 1'b0;
        clr_on    = 1'b0;
        req_set   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (pb_low) begin
                    state_nxt = ST_BASE;
                    clr       = 1'b1;
                end
            end
            ST_BASE: begin
                if (!pb_low) begin
                    state_nxt = ST_IDLE;
                end else if (tick && (count == BASE_LAST)) begin
                    state_nxt = ST_EXTRA;
                    clr       = 1'b1;
                end
            end
            ST_EXTRA: begin
                if (!pb_low) begin
                    state_nxt = ST_IDLE;
                end else if (count >= extra_sel) begin
                    if (power_on) begin
                        state_nxt = ST_WAIT_DONE;
                        req_set   = 1'b1;
                    end else begin
                        state_nxt = ST_RELEASE;
                        set_on    = 1'b1;
                        clr       = 1'b1;
                    end
                end
            end
            ST_WAIT_DONE: begin
                if (shdn_done) begin
                    state_nxt = ST_RELEASE;
                    clr_on    = 1'b1;
                    clr       = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (pb_low) begin
                    clr = 1'b1;
                end else if (tick && (count == BASE_LAST)) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state, power flag and request pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            power_on <= 1'b0;
            shdn_req <= 1'b0;
        end else begin
            state    <= state_nxt;
            shdn_req <= req_set;
            if (set_on)      power_on <= 1'b1;
            else if (clr_on) power_on <= 1'b0;
        end
    end

    // interrupt is low while a turn-off is pending or in progress
    assign int_n = !(((state == ST_EXTRA) && power_on) || (state == ST_WAIT_DONE));
endmodule

// File: rtl/pb_onoff_seq.sv
// Module: top of the pushbutton on/off debounce sequencer.
// Assumes: tick is a one-cycle enable at the timebase rate; pb_n is asynchronous.
module pb_onoff_seq #(
    parameter int CNT_W       = 8,
    parameter int BASE_TICKS  = 26,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pb_n,
    input  logic [CNT_W-1:0] on_extra,
    input  logic [CNT_W-1:0] off_extra,
    input  logic             shdn_done,
    output logic             power_on,
    output logic             int_n,
    output logic             shdn_req
);
    logic             pb_sync, cnt_clr;
    logic [CNT_W-1:0] cnt;

    pbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pb_n), .q_sync(pb_sync)
    );

    pbs_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick), .count(cnt)
    );

    pbs_ctrl #(.CNT_W(CNT_W), .BASE_TICKS(BASE_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pb_low(!pb_sync),
        .count(cnt), .on_extra(on_extra), .off_extra(off_extra),
        .shdn_done(shdn_done), .clr(cnt_clr), .power_on(power_on),
        .int_n(int_n), .shdn_req(shdn_req)
    );
endmodule

// File: rtl/pb_onoff_seq_chk.sv
// Module: port-level property checker bound to pb_onoff_seq.
// Assumes: synchronous active-low reset.
module pb_onoff_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             pb_n,
    input logic [CNT_W-1:0] on_extra,
    input logic [CNT_W-1:0] off_extra,
    input logic             shdn_done,
    input logic             power_on,
    input logic             int_n,
    input logic             shdn_req
);
    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) shdn_req |=> !shdn_req); // R6
    AST_REQ_WITH_INT: assert property (@(posedge clk) disable iff (!rst_n) shdn_req |-> (!int_n && power_on)); // R6
    AST_INT_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n) !int_n |-> power_on); // R4
    AST_OFF_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) (power_on && !shdn_done) |=> power_on); // R6
    AST_ON_NO_INT: assert property (@(posedge clk) disable iff (!rst_n) $rose(power_on) |-> int_n); // R3
    AST_OFF_RELEASES_INT: assert property (@(posedge clk) disable iff (!rst_n) $fell(power_on) |-> int_n); // R6
endmodule

bind pb_onoff_seq pb_onoff_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pb_onoff_seq_tb.sv
module pb_onoff_seq_tb;
    localparam int CW    = 8;
    localparam int BASE  = 26;
    localparam int DIV   = 4;     // clocks per tick
    localparam int NROWS = 7;
    // row: {press ticks, on_extra, off_extra}
    localparam int TBL [NROWS][3] = '{
        '{10, 5, 5},   // R2 short press while off
        '{40, 5, 5},   // R3 valid turn-on
        '{29, 0, 8},   // R5/R7 off press stops before off extra
        '{45, 0, 8},   // R6 valid turn-off
        '{29, 8, 0},   // R7 on extra longer than press
        '{36, 3, 0},   // R3 valid turn-on
        '{30, 3, 0}    // R9 zero off extra
    };

    logic clk = 0, rst_n = 0, tick = 0, pb_n = 1, shdn_done = 0;
    logic [CW-1:0] on_extra = '0, off_extra = '0;
    logic power_on, int_n, shdn_req;
    int div = 0, req_cnt = 0, n_chk = 0, n_fail = 0, cyc = 0;
    bit model_on = 0;

    pb_onoff_seq #(.CNT_W(CW), .BASE_TICKS(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pb_n(pb_n),
        .on_extra(on_extra), .off_extra(off_extra), .shdn_done(shdn_done),
        .power_on(power_on), .int_n(int_n), .shdn_req(shdn_req)
    );

    always #5 clk = ~clk;

    // timebase enable every DIV clocks
    always @(posedge clk) begin
        div  <= (div == DIV-1) ? 0 : div + 1;
        tick <= (div == DIV-1);
    end

    // count request pulses
    always @(posedge clk) if (rst_n && shdn_req) req_cnt <= req_cnt + 1;

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_ticks(int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic press(int n);
        pb_n = 0; wait_ticks(n); pb_n = 1;
    endtask

    task automatic done_pulse();
        @(negedge clk) shdn_done = 1;
        @(negedge clk) shdn_done = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int r0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "power_on", power_on, 0);
        chk("R1", "int_n", int_n, 1);
        chk("R1", "shdn_req", shdn_req, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // table walk; R10: one tick is DIV clocks, margins cover the sync flops
        for (int i = 0; i < NROWS; i++) begin
            int  low, ext;
            bit  valid;
            string tag;
            low = TBL[i][0];
            on_extra = CW'(TBL[i][1]);
            off_extra = CW'(TBL[i][2]);
            ext = model_on ? TBL[i][2] : TBL[i][1];   // R7 state picks the count
            valid = (low >= BASE + ext + 2);
            tag = !valid ? (low < BASE ? "R2" : "R7") : (model_on ? "R6" : (ext == 0 ? "R9" : "R3"));
            r0 = req_cnt;
            press(low);
            wait_ticks(1);
            if (valid && model_on) begin
                chk(tag, "held power_on", power_on, 1);
                chk(tag, "held int_n", int_n, 0);
                done_pulse();
                model_on = 0;
            end else if (valid) begin
                model_on = 1;
            end
            wait_ticks(BASE + 4);
            chk(tag, "power_on", power_on, int'(model_on));
            chk(tag, "int_n", int_n, 1);
            chk(tag, "req count", req_cnt - r0, (valid && ext >= 0 && tag == "R6") ? 1 : 0);
        end

        // R9 zero off extra was last row; turn on for directed tests
        on_extra = 3; off_extra = 8;
        press(40); wait_ticks(BASE + 4);
        chk("R3", "power_on", power_on, 1);

        // R4 interrupt only after base, R5 cancel
        r0 = req_cnt;
        pb_n = 0; wait_ticks(20);
        chk("R4", "int_n before base", int_n, 1);
        wait_ticks(10);
        chk("R4", "int_n after base", int_n, 0);
        pb_n = 1; repeat (6) @(negedge clk);
        chk("R5", "int_n cancelled", int_n, 1);
        chk("R5", "power_on", power_on, 1);
        wait_ticks(BASE + 4);
        chk("R5", "req count", req_cnt - r0, 0);

        // R6 power held until done strobe arrives late
        r0 = req_cnt;
        off_extra = 2;
        press(35); wait_ticks(40);
        chk("R6", "req count", req_cnt - r0, 1);
        chk("R6", "power_on waiting", power_on, 1);
        chk("R6", "int_n waiting", int_n, 0);
        done_pulse();
        chk("R6", "power_on after done", power_on, 0);
        chk("R6", "int_n after done", int_n, 1);
        wait_ticks(BASE + 4);

        // R8 glitch in release debounce blocks next press
        press(40);                 // turn on (on_extra 3)
        wait_ticks(10);
        pb_n = 0; wait_ticks(2); pb_n = 1;
        wait_ticks(20);
        r0 = req_cnt;
        press(40);                 // ignored: release not yet accepted
        wait_ticks(BASE + 4);
        chk("R8", "power_on after blocked press", power_on, 1);
        chk("R8", "req count", req_cnt - r0, 0);
        press(40);                 // now accepted as turn-off
        wait_ticks(1);
        chk("R8", "req count after release", req_cnt - r0, 1);
        done_pulse();
        chk("R8", "power_on", power_on, 0);

        // R1 reset while on
        wait_ticks(BASE + 4);
        press(40); wait_ticks(2);
        chk("R1", "on before reset", power_on, 1);
        @(negedge clk) rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1", "power_on in reset", power_on, 0);
        chk("R1", "int_n in reset", int_n, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule